// File: doc/BRIEF.md
# Floating-Point Min/Max Selector

This unit receives two binary floating-point operands of a parameterised width and an opcode, and returns one of them: the larger when the opcode asks for the maximum, and the smaller when it asks for the minimum. All paths are combinational, so the result is valid in the same cycle as the operands. The unit can therefore sit inside any pipeline stage that supplies its own registers and handshake.

The ordering does not use a full floating-point comparator. If the two sign bits differ, the non-negative operand is the larger one. If they match, the exponent and mantissa bits are compared as one unsigned integer, and the answer is inverted when both operands are negative. A NaN operand always loses to a number. When both operands are NaN, the output is a single canonical quiet NaN. An identifier tag is carried alongside the operands and comes out unchanged.

Top module: `fpmm_unit`

## Requirements
- R1: Output `z` always equals `a`, equals `b`, or equals the canonical quiet NaN. The canonical quiet NaN has sign 0, an all-ones exponent, mantissa MSB 1 and all other mantissa bits 0, which is 32'h7FC00000 at 32 bits. A NaN is any value with an all-ones exponent and a nonzero mantissa.
- R2: When both operands are NaN, quiet or signalling, `z` is the canonical quiet NaN.
- R3: When exactly one operand is NaN, `z` is the other operand, for both max and min.
- R4: With no NaN present and differing sign bits, the operand whose sign bit is 0 is treated as the larger one.
- R5: With no NaN present and both sign bits 0, the operand whose lower WIDTH-1 bits are the larger unsigned integer is the larger one. This also holds for denormals and infinities.
- R6: With no NaN present and both sign bits 1, the operand whose lower WIDTH-1 bits are the smaller unsigned integer is the larger one.
- R7: `op` bit 0 = 0 selects the maximum and `op` bit 0 = 1 selects the minimum. All other `op` bits have no effect on `z`.
- R8: For +0 (32'h00000000) and -0 (32'h80000000), the maximum is +0 and the minimum is -0, whatever the operand order.
- R9: `tag_out` equals `tag_in` in the same cycle, for every operand and opcode combination.
- R10: When the two non-NaN operands are bit-identical, `z` equals that value for both max and min.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First floating-point operand |
| b | input | WIDTH | Second floating-point operand |
| op | input | OP_W | Opcode; bit 0 picks min (1) or max (0) |
| tag_in | input | TAG_W | Identifier carried with the operands |
| z | output | WIDTH | Selected operand or canonical quiet NaN |
| tag_out | output | TAG_W | Copy of `tag_in` |

## Verification
The NaN override and the sign-aware ordering are evaluated in the same cycle. The bench provokes conflicts between them by pairing a NaN with a negative number, with an infinity and with a zero, under both opcodes. The result must follow the NaN rule and never the raw compare, which would rank a NaN bit pattern above infinity. Tag pass-through is active in every one of those cycles, so each vector checks the tag together with the selected value against an ordered-key reference model written in the bench.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

   // Per-operand classification derived from the raw bits.
   typedef struct packed {
      logic is_nan;
      logic is_neg;
   } fp_class_t;

   // Meaning of opcode bit 0.
   typedef enum logic {
      MM_PICK_MAX = 1'b0,
      MM_PICK_MIN = 1'b1
   } mm_pick_e;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
   import fpmm_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int EXP_W = 8
) (
   input  logic [WIDTH-1:0] v,
   output fp_class_t        cls
);
   localparam int MAN_W = WIDTH - 1 - EXP_W;

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f = v[WIDTH-2 -: EXP_W];
   assign man_f = v[MAN_W-1:0];

   always_comb begin
      cls.is_neg = v[WIDTH-1];
      cls.is_nan = (&exp_f) & (|man_f);
   end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order #(
   parameter int WIDTH     = 32,
   parameter int EXP_W     = 8,
   parameter bit SPLIT_CMP = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             b_larger
);
   localparam int MAN_W = WIDTH - 1 - EXP_W;

   logic mag_lt;   // |a| bits < |b| bits as unsigned integers

   generate
      if (SPLIT_CMP) begin : g_split
         // Two narrow compares: exponent first, then mantissa on a tie.
         logic exp_lt, exp_eq, man_lt;
         assign exp_lt = a[WIDTH-2 -: EXP_W] <  b[WIDTH-2 -: EXP_W];
         assign exp_eq = a[WIDTH-2 -: EXP_W] == b[WIDTH-2 -: EXP_W];
         assign man_lt = a[MAN_W-1:0] < b[MAN_W-1:0];
         assign mag_lt = exp_lt | (exp_eq & man_lt);
      end else begin : g_flat
         // One wide unsigned compare over exponent and mantissa.
         assign mag_lt = a[WIDTH-2:0] < b[WIDTH-2:0];
      end
   endgenerate

   always_comb begin
      if (a[WIDTH-1] != b[WIDTH-1])
         b_larger = a[WIDTH-1];            // negative a loses
      else
         b_larger = mag_lt ^ a[WIDTH-1];   // both negative: invert
   end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
   import fpmm_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int EXP_W = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  fp_class_t        cls_a,
   input  fp_class_t        cls_b,
   input  logic             b_larger,
   input  mm_pick_e         pick,
   output logic [WIDTH-1:0] z
);
   localparam int MAN_W = WIDTH - 1 - EXP_W;
   localparam logic [WIDTH-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic unused_neg;
   assign unused_neg = cls_a.is_neg ^ cls_b.is_neg;

   always_comb begin
      if (cls_a.is_nan && cls_b.is_nan)
         z = QNAN;
      else if (cls_a.is_nan)
         z = b;
      else if (cls_b.is_nan)
         z = a;
      else if (b_larger ^ (pick == MM_PICK_MIN))
         z = b;
      else
         z = a;
   end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
   import fpmm_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int EXP_W     = 8,
   parameter int OP_W      = 2,
   parameter int TAG_W     = 4,
   parameter bit SPLIT_CMP = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [OP_W-1:0]  op,
   input  logic [TAG_W-1:0] tag_in,
   output logic [WIDTH-1:0] z,
   output logic [TAG_W-1:0] tag_out
);
   localparam int MAN_W = WIDTH - 1 - EXP_W;

   generate
      if (EXP_W < 2 || MAN_W < 2) begin : g_bad_format
         $error("fpmm_unit: EXP_W and mantissa width must both be at least 2");
      end
      if (OP_W < 1 || TAG_W < 1) begin : g_bad_side
         $error("fpmm_unit: OP_W and TAG_W must be at least 1");
      end
   endgenerate

   fp_class_t cls_a, cls_b;
   logic      b_larger;
   mm_pick_e  pick;
   logic      unused_op;

   assign pick      = mm_pick_e'(op[0]);
   assign unused_op = ^op;

   fpmm_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls_a (.v(a), .cls(cls_a));
   fpmm_classify #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_cls_b (.v(b), .cls(cls_b));

   fpmm_order #(.WIDTH(WIDTH), .EXP_W(EXP_W), .SPLIT_CMP(SPLIT_CMP)) u_order (
      .a(a), .b(b), .b_larger(b_larger)
   );

   fpmm_select #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_select (
      .a(a), .b(b), .cls_a(cls_a), .cls_b(cls_b),
      .b_larger(b_larger), .pick(pick), .z(z)
   );

   assign tag_out = tag_in;
endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk #(
   parameter int WIDTH = 32,
   parameter int EXP_W = 8
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             op_lsb,
   input logic [WIDTH-1:0] z
);
   localparam int MAN_W = WIDTH - 1 - EXP_W;
   localparam logic [WIDTH-1:0] CANON =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic a_nan, b_nan;
   assign a_nan = (&a[WIDTH-2 -: EXP_W]) && (|a[MAN_W-1:0]);
   assign b_nan = (&b[WIDTH-2 -: EXP_W]) && (|b[MAN_W-1:0]);

   always_comb begin
      if (!$isunknown({a, b, op_lsb, z})) begin
         assert_member_R1: assert (z == a || z == b || z == CANON)
            else $error("R1: result is not a, b or canonical NaN");
         if (a_nan && b_nan) begin
            assert_both_nan_R2: assert (z == CANON)
               else $error("R2: two NaNs did not give canonical NaN");
         end
         if (a_nan && !b_nan) begin
            assert_a_nan_R3: assert (z == b)
               else $error("R3: NaN a did not yield b");
         end
         if (b_nan && !a_nan) begin
            assert_b_nan_R3: assert (z == a)
               else $error("R3: NaN b did not yield a");
         end
         if (!a_nan && !b_nan && a[WIDTH-1] != b[WIDTH-1]) begin
            assert_sign_rule_R4: assert (z[WIDTH-1] == op_lsb)
               else $error("R4: sign of result does not follow opcode");
         end
      end
   end
endmodule

bind fpmm_unit fpmm_unit_chk #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_chk (
   .a(a), .b(b), .op_lsb(op[0]), .z(z)
);

// File: tb/fpmm_unit_test.sv
module fpmm_unit_test;
   localparam int W  = 32;
   localparam int OW = 2;
   localparam int TW = 4;
   localparam logic [W-1:0] QNAN = 32'h7FC00000;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [W-1:0]  a, b, z;
   logic [OW-1:0] op;
   logic [TW-1:0] tag_in, tag_out;

   int n_vec  = 0;
   int n_fail = 0;

   fpmm_unit #(.WIDTH(W), .EXP_W(8), .OP_W(OW), .TAG_W(TW)) uut (
      .a(a), .b(b), .op(op), .tag_in(tag_in), .z(z), .tag_out(tag_out)
   );

   function automatic logic isnan(input logic [W-1:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 0);
   endfunction

   // Monotone key: larger key means larger value (+0 above -0).
   function automatic logic [W-1:0] okey(input logic [W-1:0] v);
      return v[31] ? ~v : (v | 32'h80000000);
   endfunction

   function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic want_min);
      logic bbig;
      if (isnan(x) && isnan(y)) return QNAN;
      if (isnan(x)) return y;
      if (isnan(y)) return x;
      bbig = okey(y) > okey(x);
      if (want_min) return bbig ? x : y;
      return bbig ? y : x;
   endfunction

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [OW-1:0] o, input logic [TW-1:0] t,
                        input string req);
      logic [W-1:0] exp_z;
      @(posedge clk);
      a = x; b = y; op = o; tag_in = t;
      @(negedge clk);
      exp_z = model(x, y, o[0]);
      n_vec++;
      if (z !== exp_z) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h op=%0d z=%h expected %h", req, x, y, o, z, exp_z);
      end
      if (tag_out !== t) begin
         n_fail++;
         $display("FAIL R9: tag_out=%h expected %h", tag_out, t);
      end
   endtask

   task automatic t_idle;   // zero inputs right after start
      apply(32'h0, 32'h0, 2'd0, 4'h0, "R10");
   endtask

   task automatic t_zeros;   // R8
      for (int o = 0; o < 2; o++) begin
         apply(32'h00000000, 32'h80000000, OW'(o), 4'h1, "R8");
         apply(32'h80000000, 32'h00000000, OW'(o), 4'h2, "R8");
      end
   endtask

   task automatic t_signs;   // R4, R5 with infinities
      for (int o = 0; o < 2; o++) begin
         apply(32'hBF800000, 32'h3F800000, OW'(o), 4'h3, "R4");
         apply(32'h7F800000, 32'hFF800000, OW'(o), 4'h4, "R4");
         apply(32'h7F800000, 32'h7F7FFFFF, OW'(o), 4'h5, "R5");
         apply(32'h40000000, 32'h3FFFFFFF, OW'(o), 4'h6, "R5");
      end
   endtask

   task automatic t_negatives;   // R6
      for (int o = 0; o < 2; o++) begin
         apply(32'hC0000000, 32'hBF800000, OW'(o), 4'h7, "R6");
         apply(32'hFF800000, 32'hC2C80000, OW'(o), 4'h8, "R6");
         apply(32'h80000001, 32'h80000002, OW'(o), 4'h9, "R6");
      end
   endtask

   task automatic t_denormals;   // R5
      for (int o = 0; o < 2; o++) begin
         apply(32'h00000001, 32'h007FFFFF, OW'(o), 4'hA, "R5");
         apply(32'h00800000, 32'h007FFFFF, OW'(o), 4'hB, "R5");
      end
   endtask

   task automatic t_nans;   // R2, R3: NaN against negatives, infinities, zero
      for (int o = 0; o < 2; o++) begin
         apply(32'h7FC00001, 32'hFF800001, OW'(o), 4'hC, "R2");
         apply(32'hFFFFFFFF, 32'h7F800001, OW'(o), 4'hD, "R2");
         apply(32'h7FC00000, 32'hC1200000, OW'(o), 4'hE, "R3");
         apply(32'hFF800000, 32'h7F800001, OW'(o), 4'hF, "R3");
         apply(32'h80000000, 32'hFFC00000, OW'(o), 4'h0, "R3");
         apply(32'h7FA00000, 32'h7F800000, OW'(o), 4'h1, "R3");
      end
   endtask

   task automatic t_op_high;   // R7: bit 1 must not change the result
      apply(32'h3F800000, 32'h40000000, 2'd2, 4'h2, "R7");
      apply(32'h3F800000, 32'h40000000, 2'd3, 4'h3, "R7");
      apply(32'hC0000000, 32'h40000000, 2'd2, 4'h4, "R7");
      apply(32'hC0000000, 32'h40000000, 2'd3, 4'h5, "R7");
   endtask

   task automatic t_equal;   // R10
      for (int o = 0; o < 2; o++) begin
         apply(32'h42280000, 32'h42280000, OW'(o), 4'h6, "R10");
         apply(32'hC2280000, 32'hC2280000, OW'(o), 4'h7, "R10");
      end
   endtask

   task automatic t_random;   // R1 across mixed patterns
      for (int i = 0; i < 3000; i++) begin
         logic [W-1:0] x, y;
         x = $urandom();
         y = $urandom();
         if (i % 7 == 0) x[30:23] = 8'hFF;
         if (i % 11 == 0) y[30:23] = 8'hFF;
         if (i % 5 == 0) y[31] = x[31];
         if (i % 13 == 0) y[30:23] = x[30:23];
         apply(x, y, OW'($urandom()), TW'($urandom()), "R1");
      end
   endtask

   initial begin
      a = '0; b = '0; op = '0; tag_in = '0;
      t_idle();
      t_zeros();
      t_signs();
      t_negatives();
      t_denormals();
      t_nans();
      t_op_high();
      t_equal();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule